// File: doc/BRIEF.md
# Four-Lane Tree Reduction Adder

This block totals a batch of 128 signed integers with four processing lanes. After a start pulse, each lane takes one operand per cycle from its own input port for 32 consecutive cycles and keeps a local partial sum. The four partial sums are then merged in two rounds. Data moves only over three point-to-point links, joining lanes 1–2, 1–3 and 3–4, and the grand total ends up in lane 1.

Each link transfer takes two cycles and each reduction add takes one. As a result, completion is fixed at 38 cycles: 32 local accumulations, a 2-cycle transfer, an add, a second 2-cycle transfer and the final add. A cycle counter output lets the surrounding logic or a testbench see where the reduction stands.

Top module: `tree_sum4`

## Requirements
- R1: Lane k (k = 1..4) samples its own operand port on each of the 32 rising edges after the edge that accepts start, and adds every sampled word to its own partial sum. Operand j of lane k is overall operand (k-1)*32 + j.
- R2: The result is the two's-complement sum of all 128 operands, W+7 bits wide. It is exact at both extremes: all operands at the most positive value, and all at the most negative value.
- R3: Round one moves lane 2's sum to lane 1 and lane 4's sum to lane 3 at the same time, over two-cycle links. Lanes 1 and 3 then add in parallel. Round two moves lane 3's sum to lane 1 over a two-cycle link, and lane 1 forms the total.
- R4: `done` is high in the cycle that follows the 38th rising edge, counting from the edge that samples the first operand. It is never high earlier in a run.
- R5: `done` is high for exactly one cycle per run.
- R6: `total` changes only on the edge that raises `done`. It holds its value through idle cycles and through the next run until that run completes.
- R7: A start pulse sampled while a reduction is in progress has no effect on timing or result. A start pulse sampled in the cycle where `done` is high begins a new run.
- R8: While reset is asserted, and after it is released, `done` is 0, `total` is 0 and `cyc` is 0.
- R9: `cyc` becomes 0 on the edge that accepts start. It then increases by one on each edge of a run. It reads 38 while `done` is high and holds that value until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a reduction; ignored while one is running |
| op_l1 | input | W | Lane 1 operand, one word per cycle |
| op_l2 | input | W | Lane 2 operand |
| op_l3 | input | W | Lane 3 operand |
| op_l4 | input | W | Lane 4 operand |
| done | output | 1 | One-cycle pulse when the total is valid |
| total | output | W+7 | Signed grand total, held between runs |
| cyc | output | 6 | Cycles since the accepting start edge |

## Verification
Two functions can fall in the same cycle: the completion pulse of one run, and the acceptance of a start for the next. The bench chains most runs back to back, raising start in the very cycle `done` is high. It judges that pairing by three things: the new run's `done` arrives exactly 38 edges later, its total is exact, and the old total stays visible until then. Separately, stray start pulses are placed inside the local phase, during the transfers and on the final edge. None of them may shift the completion cycle or alter the sum.

// File: rtl/tree_sum4.sv
module tree_sum4 #(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic signed [W-1:0]    op_l1,
  input  logic signed [W-1:0]    op_l2,
  input  logic signed [W-1:0]    op_l3,
  input  logic signed [W-1:0]    op_l4,
  output logic                   done,
  output logic signed [W+6:0]    total,
  output logic [5:0]             cyc
);

  localparam int LANES    = 4;
  localparam int PER_LANE = 32;
  localparam int HOP      = 2;
  localparam int AW       = W + 7;
  localparam int CW       = 6;
  localparam int NLINK    = 3;
  localparam logic [CW-1:0] C_SEND1 = CW'(PER_LANE);
  localparam logic [CW-1:0] C_ADD1  = CW'(PER_LANE + HOP);
  localparam logic [CW-1:0] C_SEND2 = CW'(PER_LANE + HOP + 1);
  localparam logic [CW-1:0] C_ADD2  = CW'(PER_LANE + 2*HOP + 1);
  localparam logic [CW-1:0] C_END   = CW'(PER_LANE + 2*HOP + 2);

  logic                 busy;
  logic                 take;
  logic signed [W-1:0]  op   [LANES];
  logic signed [AW-1:0] acc  [LANES];
  logic signed [AW-1:0] src  [NLINK];
  logic signed [AW-1:0] lk_d [NLINK][HOP];
  logic                 lk_v [NLINK][HOP];

  assign take  = start && !busy;
  assign op[0] = op_l1;
  assign op[1] = op_l2;
  assign op[2] = op_l3;
  assign op[3] = op_l4;

  // link 0: lane2 -> lane1, link 1: lane4 -> lane3, link 2: lane3 -> lane1
  assign src[0] = acc[1];
  assign src[1] = acc[3];
  assign src[2] = acc[2];

  function automatic logic [CW-1:0] send_at(input int j);
    return (j == 2) ? C_SEND2 : C_SEND1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cyc  <= '0;
      done <= 1'b0;
    end else begin
      done <= busy && (cyc == C_ADD2);
      if (take) begin
        busy <= 1'b1;
        cyc  <= '0;
      end else if (busy) begin
        cyc <= cyc + CW'(1);
        if (cyc == C_ADD2) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) acc[i] <= '0;
    end else if (take) begin
      for (int i = 0; i < LANES; i++) acc[i] <= '0;
    end else if (busy && cyc < C_SEND1) begin
      for (int i = 0; i < LANES; i++) acc[i] <= acc[i] + AW'(op[i]);
    end else if (busy && cyc == C_ADD1) begin
      acc[0] <= acc[0] + lk_d[0][HOP-1];
      acc[2] <= acc[2] + lk_d[1][HOP-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NLINK; j++)
        for (int i = 0; i < HOP; i++) begin
          lk_d[j][i] <= '0;
          lk_v[j][i] <= 1'b0;
        end
    end else begin
      for (int j = 0; j < NLINK; j++) begin
        lk_d[j][0] <= src[j];
        lk_v[j][0] <= busy && (cyc == send_at(j));
        for (int i = 1; i < HOP; i++) begin
          lk_d[j][i] <= lk_d[j][i-1];
          lk_v[j][i] <= lk_v[j][i-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     total <= '0;
    else if (busy && cyc == C_ADD2) total <= acc[0] + lk_d[2][HOP-1];
  end

  AST_ROUND1_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc == C_ADD1) |-> (lk_v[0][HOP-1] && lk_v[1][HOP-1] && !lk_v[2][HOP-1])); // R3
  AST_ROUND2_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc == C_ADD2) |-> (lk_v[2][HOP-1] && !lk_v[0][HOP-1])); // R3
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc == C_END && !busy)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_TOTAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(total)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cyc == $past(cyc) + CW'(1))); // R7
  AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(cyc)); // R9

endmodule

// File: tb/tree_sum4_test.sv
module tree_sum4_test;
  localparam int W  = 16;
  localparam int AW = W + 7;
  localparam int N  = 128;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_n;
  logic                 start;
  logic signed [W-1:0]  op [4];
  logic                 done;
  logic signed [AW-1:0] total;
  logic [5:0]           cyc;

  tree_sum4 #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_l1(op[0]), .op_l2(op[1]), .op_l3(op[2]), .op_l4(op[3]),
    .done(done), .total(total), .cyc(cyc)
  );

  int n_chk = 0;
  int n_fail = 0;
  longint prev_total = 0;
  logic signed [W-1:0] vec [N];
  logic [31:0] seed = 32'h1234_5679;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // caller sits at a negedge; spur = step at which a stray start is raised (-1: none)
  task automatic run(input int spur);
    longint exp = 0;
    for (int i = 0; i < N; i++) exp += longint'(vec[i]);
    start = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 38; k++) begin
      for (int l = 0; l < 4; l++) op[l] = (k < 32) ? vec[l*32 + k] : '0; // R1 lane ownership
      start = (k == spur);
      @(negedge clk);
      chk(cyc == 6'(k + 1), "R9 cyc", longint'(cyc), longint'(k + 1));
      if (k < 37) begin
        chk(done == 1'b0, "R4 early done", longint'(done), 0);
        chk(longint'(total) == prev_total, "R6 total held", longint'(total), prev_total);
      end else begin
        chk(done == 1'b1, "R4 done at 38", longint'(done), 1);
        chk(longint'(total) == exp, "R2 sum", longint'(total), exp);
      end
    end
    start = 1'b0;
    prev_total = exp;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R5 single pulse", longint'(done), 0);
      chk(longint'(total) == prev_total, "R6 idle hold", longint'(total), prev_total);
      chk(cyc == 6'd38, "R9 cyc hold", longint'(cyc), 38);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    for (int l = 0; l < 4; l++) op[l] = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R8 reset done", longint'(done), 0);
    chk(total == '0, "R8 reset total", longint'(total), 0);
    chk(cyc == '0, "R8 reset cyc", longint'(cyc), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cyc == '0 && total == '0 && done == 1'b0, "R8 after release", longint'(cyc), 0);

    // extremes and patterns (R2), runs chained back to back (R7)
    for (int i = 0; i < N; i++) vec[i] = 16'sd32767;
    run(-1);
    for (int i = 0; i < N; i++) vec[i] = -16'sd32768;
    run(-1);
    idle(1);
    for (int i = 0; i < N; i++) vec[i] = '0;
    run(-1);
    for (int i = 0; i < N; i++) vec[i] = (i % 2 == 0) ? 16'sd32767 : -16'sd32768;
    run(-1);
    for (int i = 0; i < N; i++) vec[i] = W'(i * 211 - 13000);
    run(-1);
    idle(3);

    // stray start pulses during a run (R7)
    begin
      int spots [6] = '{0, 5, 31, 32, 35, 37};
      for (int s = 0; s < 6; s++) begin
        for (int i = 0; i < N; i++) begin
          seed = nxt(seed);
          vec[i] = seed[W-1:0];
        end
        run(spots[s]);
        if (s % 2 == 1) idle(2);
      end
    end

    // one-hot sweep over every operand position, each lane and slot (R1, R3)
    for (int p = 0; p < N; p++) begin
      for (int i = 0; i < N; i++) vec[i] = '0;
      vec[p] = W'(p * 251 - 16000);
      run(-1);
    end

    // two-position sweep across lane pairs on different links (R3)
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        for (int i = 0; i < N; i++) vec[i] = '0;
        vec[a*32 + 7]  = W'(1000 * (a + 1));
        vec[b*32 + 30] = W'(-3 * (b + 5));
        run(-1);
      end
    idle(2);

    summary();
    $finish;
  end
endmodule